// File: doc/BRIEF.md
# Event-Action PWM Channel

This block generates one pulse-width-modulated output from a small set of write-only registers. A prescaler divides the module clock into a step tick. An up-counter advances on each tick, runs from 0 up to a programmed top value inclusive, and then wraps to 0. While the counter runs, several events can occur: the zero point, a compare match, and the top (period) point. Each event has its own two-bit action code that sets, clears or inverts the output, or leaves it unchanged. The output level therefore comes from this action table and is not fixed by a rule such as "high below compare".

The top value and the compare value are written into holding registers. The counter loads them into its working copies while the channel is stopped, and again at each wrap. A new setting therefore never cuts a cycle short. The output pin carries the waveform only while the output-enable bit is set. The waveform register is held low whenever the channel is not both enabled and started.

Top module: `pwm_evt`

## Requirements
- R1: The output repeats every (P+1)*(N+1) module clocks, where P is the prescaler value and N is the top value. With P=31 and N=999 the output period is 32000 clocks, which is 1 kHz from a 32 MHz clock.
- R2: The counter steps through 0..N inclusive, so N=9 with P=1 gives a 20-clock output period.
- R3: When the count reaches 0, the zero-point action is applied. With the zero action set to high, the output rises at the start of every cycle.
- R4: When the count equals the compare value C, the compare-up action is applied. With zero=high and compare-up=low, the high time is C*(P+1) clocks. For example, C=3 and P=1 give 6 clocks high in a 20-clock period, and C=500, N=999 gives 50 % duty.
- R5: When the count equals N, the period-point action is applied. With zero=none, compare-up=low (C=3) and period=high, N=9 and P=1 give 8 clocks high per 20.
- R6: The compare-down action never fires while counting up. Setting it to toggle leaves the waveform of R4 unchanged.
- R7: When several events fall on the same count, the compare-up action wins over the period action, and the period action wins over the zero action. An event whose action is none yields to the next event. With C=0, zero=high and compare-up=low, the output stays low for the whole cycle.
- R8: The toggle action inverts the output. With only zero=toggle, N=9 and P=1, the output is high for 20 clocks and low for 20 clocks.
- R9: Compare and top values written while the channel is running take effect only from the next wrap. The cycle already under way keeps its old high time.
- R10: The output pin is low whenever the output-enable bit is clear, even while the channel is counting.
- R11: The output is low after reset. It is also low while the channel is not both enabled and started, and counting begins only after start is set.
- R12: Write map, with data taken on a clock where wr_en is high:
  - address 0 is control: bit0 enable, bit1 start, bit2 output enable.
  - address 1 is the prescaler.
  - address 2 is the top value.
  - address 3 is the compare value.
  - address 4 holds the actions: bits 1:0 zero, 3:2 compare-up, 5:4 compare-down, 7:6 period.
  - The action codes are 0 none, 1 low, 2 high, 3 toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address |
| wr_data | input | DATA_W (16) | Register write data |
| pwm_o | output | 1 | PWM output pin |

## Verification
Two events can land on the same count: the zero point and a compare match when the compare value is 0, or a period point and a zero point. Each such collision is resolved by a fixed priority. The bench forces the first collision by programming compare 0 with zero=high and compare-up=low, and judges it by watching that the pin never rises over several cycles. The second case where work coincides is a register write that arrives in the middle of a cycle. The new compare value is written just after a rising edge, and the scoreboard expects the old high time for that cycle and the new one only afterwards.

// File: rtl/pwm_evt_pkg.sv
// Package: shared types for the event-action PWM channel.
// Assumes: action codes are fixed at two bits and used by all submodules.
package pwm_evt_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } act_e;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_PSC  = 3'd1;
    localparam logic [2:0] ADR_TOP  = 3'd2;
    localparam logic [2:0] ADR_CMP  = 3'd3;
    localparam logic [2:0] ADR_ACT  = 3'd4;

endpackage

// File: rtl/pwm_evt_regs.sv
// Module: write-only register file of the PWM channel.
// Holds control bits, prescaler, the holding copies of top/compare, and
// the four event actions. Assumes PSC_W and CNT_W do not exceed DATA_W.
module pwm_evt_regs
    import pwm_evt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int PSC_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ch_en,
    output logic              ch_start,
    output logic              out_en,
    output logic [PSC_W-1:0]  psc,
    output logic [CNT_W-1:0]  top_hold,
    output logic [CNT_W-1:0]  cmp_hold,
    output act_e              act_zero,
    output act_e              act_cup,
    output act_e              act_cdn,
    output act_e              act_per
);

    // Decode a write into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_en    <= 1'b0;
            ch_start <= 1'b0;
            out_en   <= 1'b0;
            psc      <= '0;
            top_hold <= '0;
            cmp_hold <= '0;
            act_zero <= ACT_NONE;
            act_cup  <= ACT_NONE;
            act_cdn  <= ACT_NONE;
            act_per  <= ACT_NONE;
        end else if (wr_en) begin
            case (3'(wr_addr))
                ADR_CTRL: begin
                    ch_en    <= wr_data[0];
                    ch_start <= wr_data[1];
                    out_en   <= wr_data[2];
                end
                ADR_PSC: psc      <= wr_data[PSC_W-1:0];
                ADR_TOP: top_hold <= wr_data[CNT_W-1:0];
                ADR_CMP: cmp_hold <= wr_data[CNT_W-1:0];
                ADR_ACT: begin
                    act_zero <= act_e'(wr_data[1:0]);
                    act_cup  <= act_e'(wr_data[3:2]);
                    act_cdn  <= act_e'(wr_data[5:4]);
                    act_per  <= act_e'(wr_data[7:6]);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pwm_evt_prescale.sv
// Module: clock prescaler producing a one-clock step tick.
// Emits tick once every (psc+1) clocks while running; idle counter sits
// at zero when stopped. Uses >= so a lowered psc never stalls the count.
module pwm_evt_prescale #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    logic [PSC_W-1:0] div_q;

    // Tick when the divider has reached the programmed value.
    assign tick = running && (div_q >= psc);

    // Advance the divider, restarting at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) div_q <= '0;
        else if (tick)          div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/pwm_evt_counter.sv
// Module: up-counter 0..top with working copies of top and compare.
// Working copies load from the holding registers while stopped and at wrap.
module pwm_evt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             tick,
    input  logic [CNT_W-1:0] top_hold,
    input  logic [CNT_W-1:0] cmp_hold,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] top_act,
    output logic [CNT_W-1:0] cmp_act,
    output logic             wrap
);

    // Wrap happens on the tick that leaves the top count.
    assign wrap = tick && (cnt == top_act);

    // Step the counter on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) cnt <= '0;
        else if (wrap)          cnt <= '0;
        else if (tick)          cnt <= cnt + 1'b1;
    end

    // Refresh working top/compare only when stopped or at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_act <= '0;
            cmp_act <= '0;
        end else if (!running || wrap) begin
            top_act <= top_hold;
            cmp_act <= cmp_hold;
        end
    end

endmodule

// File: rtl/pwm_evt_wave.sv
// Module: event detector and action-table output register.
// Events are evaluated once per count, in the clock after the count is
// entered. Priority: compare-up > compare-down > period > zero; an event
// set to none yields. Output is forced low when not running.
module pwm_evt_wave
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] top_act,
    input  logic [CNT_W-1:0] cmp_act,
    input  act_e             act_zero,
    input  act_e             act_cup,
    input  act_e             act_cdn,
    input  act_e             act_per,
    output logic             evt,
    output logic             wave
);

    localparam logic DIR_UP = 1'b1;

    logic run_q, tick_q;
    logic ev_zero, ev_per, ev_cup, ev_cdn;
    act_e sel;

    // Remember the run state and the tick so the new count is seen once.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            run_q  <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            run_q  <= 1'b1;
            tick_q <= tick;
        end
    end

    assign evt     = running && (!run_q || tick_q);
    assign ev_zero = (cnt == '0);
    assign ev_per  = (cnt == top_act);
    assign ev_cup  = (cnt == cmp_act) && DIR_UP;
    assign ev_cdn  = (cnt == cmp_act) && !DIR_UP;

    // Pick the action of the highest-priority event that does something.
    always_comb begin
        sel = ACT_NONE;
        if (ev_zero && act_zero != ACT_NONE) sel = act_zero;
        if (ev_per  && act_per  != ACT_NONE) sel = act_per;
        if (ev_cdn  && act_cdn  != ACT_NONE) sel = act_cdn;
        if (ev_cup  && act_cup  != ACT_NONE) sel = act_cup;
    end

    // Apply the selected action to the waveform register.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) wave <= 1'b0;
        else if (evt) begin
            case (sel)
                ACT_LOW:    wave <= 1'b0;
                ACT_HIGH:   wave <= 1'b1;
                ACT_TOGGLE: wave <= ~wave;
                default:    wave <= wave;
            endcase
        end
    end

endmodule

// File: rtl/pwm_evt.sv
// Module: top of the single-channel event-action PWM.
// Wires register file, prescaler, counter and waveform stage together and
// gates the pin with the output enable. Assumes a single clock domain.
module pwm_evt
    import pwm_evt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int PSC_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_o
);

    logic             ch_en, ch_start, out_en, running, tick, wrap, evt, wave;
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] top_hold, cmp_hold, cnt, top_act, cmp_act;
    act_e             act_zero, act_cup, act_cdn, act_per;

    assign running = ch_en && ch_start;
    assign pwm_o   = wave && out_en;

    pwm_evt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSC_W(PSC_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ch_en(ch_en), .ch_start(ch_start), .out_en(out_en), .psc(psc),
        .top_hold(top_hold), .cmp_hold(cmp_hold),
        .act_zero(act_zero), .act_cup(act_cup), .act_cdn(act_cdn), .act_per(act_per)
    );

    pwm_evt_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .running(running), .psc(psc), .tick(tick)
    );

    pwm_evt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .running(running), .tick(tick),
        .top_hold(top_hold), .cmp_hold(cmp_hold),
        .cnt(cnt), .top_act(top_act), .cmp_act(cmp_act), .wrap(wrap)
    );

    pwm_evt_wave #(.CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .running(running), .tick(tick),
        .cnt(cnt), .top_act(top_act), .cmp_act(cmp_act),
        .act_zero(act_zero), .act_cup(act_cup), .act_cdn(act_cdn), .act_per(act_per),
        .evt(evt), .wave(wave)
    );

endmodule

// File: rtl/pwm_evt_checker.sv
// Module: assertion checker bound into pwm_evt.
// Observes internal run state, counter and waveform; drives nothing.
module pwm_evt_checker
    import pwm_evt_pkg::*;
#(
    parameter int PSC_W = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             tick,
    input logic             wrap,
    input logic             evt,
    input logic             wave,
    input logic             pwm_o,
    input logic [PSC_W-1:0] psc,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] top_act,
    input logic [CNT_W-1:0] cmp_act,
    input act_e             act_cup
);

    // R1: a nonzero prescaler never gives back-to-back ticks
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psc != '0) |=> (!tick || psc != $past(psc)));

    // R2: count never exceeds the working top value
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= top_act));

    // R7: a compare hit with action low wins and leaves the output low
    a_r7_cmp_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && cnt == cmp_act && act_cup == ACT_LOW) |=> !wave);

    // R9: working compare/top stay fixed between wraps while running
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> ($stable(cmp_act) && $stable(top_act)));

    // R11: stopped channel drives the pin low
    a_r11_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !pwm_o);

endmodule

bind pwm_evt pwm_evt_checker #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .tick(tick), .wrap(wrap),
    .evt(evt), .wave(wave), .pwm_o(pwm_o), .psc(psc), .cnt(cnt),
    .top_act(top_act), .cmp_act(cmp_act), .act_cup(act_cup)
);

// File: tb/pwm_evt_test.sv
// Bench: scoreboard of expected (high time, period) pairs per output cycle.
module pwm_evt_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct { int hi; int per; string tag; } item_t;
    item_t exp_q[$];

    int cyc = 0;
    int last_rise = 0;
    int last_fall = 0;
    bit have_rise = 1'b0;
    bit prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_evt uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .pwm_o(pwm_o));

    // Monitor: measure each output cycle and compare with the queue head.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (pwm_o && !prev) begin
            if (have_rise && exp_q.size() > 0) begin
                item_t e;
                e = exp_q.pop_front();
                checks++;
                if ((last_fall - last_rise) != e.hi || (cyc - last_rise) != e.per) begin
                    fails++;
                    $display("FAIL %s: hi/per %0d/%0d expected %0d/%0d", e.tag,
                             last_fall - last_rise, cyc - last_rise, e.hi, e.per);
                end
            end
            last_rise = cyc;
            have_rise = 1'b1;
        end
        if (!pwm_o && prev) last_fall = cyc;
        prev = pwm_o;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    // R12: register write through the map
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input int hi, input int per, input int n, input string tag);
        for (int i = 0; i < n; i++) exp_q.push_back('{hi, per, tag});
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    // Count clocks with the pin high over a window.
    task automatic high_count(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o) h++;
        end
    endtask

    // Stop (checking R11 low), rearm the monitor, start with outputs on.
    task automatic restart();
        wr(3'd0, 16'h0000);
        repeat (3) @(negedge clk);
        chk(pwm_o == 1'b0, "R11 stop", pwm_o, 0);
        have_rise = 1'b0;
        wr(3'd0, 16'h0007);
    endtask

    initial begin
        int h;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwm_o == 1'b0, "R11 reset", pwm_o, 0);

        // P=1, N=9, C=3, zero=high, compare-up=low
        wr(3'd1, 16'd1);
        wr(3'd2, 16'd9);
        wr(3'd3, 16'd3);
        wr(3'd4, 16'h0006);
        wr(3'd0, 16'h0005);
        high_count(40, h);
        chk(h == 0, "R11 no start", h, 0);

        // R2 R3 R4 basic duty
        have_rise = 1'b0;
        wr(3'd0, 16'h0007);
        push(6, 20, 3, "R4 duty");
        drain();

        // R6 compare-down toggle has no effect
        wr(3'd4, 16'h0036);
        restart();
        push(6, 20, 2, "R6 cdn ignored");
        drain();

        // R5 period action
        wr(3'd4, 16'h0084);
        restart();
        push(8, 20, 2, "R5 period act");
        drain();

        // R8 toggle at zero
        wr(3'd4, 16'h0003);
        restart();
        push(20, 40, 2, "R8 toggle");
        drain();

        // R7 compare 0 beats zero action
        wr(3'd4, 16'h0006);
        wr(3'd3, 16'd0);
        restart();
        high_count(60, h);
        chk(h == 0, "R7 zero duty", h, 0);

        // R9 mid-cycle compare write
        wr(3'd3, 16'd3);
        restart();
        push(6, 20, 1, "R9 before");
        drain();
        @(posedge pwm_o);
        repeat (2) @(negedge clk);
        push(6, 20, 1, "R9 old cycle");
        push(12, 20, 1, "R9 new cycle");
        wr(3'd3, 16'd6);
        drain();

        // R10 output enable gates the pin
        wr(3'd0, 16'h0003);
        high_count(40, h);
        chk(h == 0, "R10 oe off", h, 0);
        wr(3'd0, 16'h0007);
        high_count(40, h);
        chk(h == 24, "R10 oe on", h, 24);

        // R1 32 MHz / 32 / 1000 = 1 kHz: 32000 clocks, 50 %
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'd31);
        wr(3'd2, 16'd999);
        wr(3'd3, 16'd500);
        restart();
        push(16000, 32000, 1, "R1 1kHz");
        drain();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(negedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule